// File: doc/BRIEF.md
# I3C Target In-Band Interrupt Requester

This block lets an I3C target ask the controller for attention by putting its own dynamic address on the bus. It holds a request raised by a one-cycle strobe. It watches the oversampled SCL and SDA lines until the bus has been quiet for a programmable number of cycles. It then pulls SDA low to form a Start and sends its 7-bit dynamic address, most significant bit first, followed by a read bit. SDA is open-drain, so the block only ever pulls the line low or lets it go. It checks every bit it lets go, so it notices when another party is holding the line low.

A controller whose bus-free wait is shorter may address the same target at the same moment. The block takes part in any address header that follows a Start (never a Restart) while a request is pending, and resolves the contention bit by bit. When the transfer is settled, it pulses `done` for one cycle and presents a 2-bit outcome: accepted, refused, lost to a controller write, or a collided read that ended in a passive NACK. A request that was not accepted stays latched and is retried after the next quiet period.

The data that follows an accepted request, and what the controller does after accepting it, belong to other logic.

Top module: `ibi_requester`

## Requirements
- R1: While reset is held and on the first cycle after it, `sda_pull_en`, `busy` and `done` are 0 and `outcome` is 00.
- R2: With a request pending, the block pulls SDA low to form a Start only after SCL and SDA have both been high for `avail_cycles` cycles in a row, on a bus that has seen no Start since its last Stop. Any edge on either line restarts this count.
- R3: In a header that follows a Start while a request is pending, the block places one bit after each SCL falling edge. It sends the dynamic address MSB first and then a read bit of 1. It pulls SDA low for a 0 and releases it for a 1, and it also releases SDA for the acknowledge bit. For address 0x55, the wire carries 0xAB across the eight bits when nobody else pulls.
- R4: If SDA reads low at an SCL rising edge during an address bit the block is releasing, the block releases SDA for the rest of that transfer. It gives no `done` pulse and keeps the request.
- R5: If all address bits match and SDA reads low during the read/write bit, the block pulses `done` with outcome 10 (lost to a controller write) and keeps the request.
- R6: If SDA reads low during the acknowledge bit, the outcome is 00 (accepted), the request is cleared, and `busy` falls once the bus is idle.
- R7: If SDA reads high during the acknowledge bit of a header whose Start the block drove itself, the outcome is 01 (refused) and the request is kept.
- R8: If SDA reads high during the acknowledge bit of a header whose Start came from the controller, the outcome is 11 (passive NACK) and the request is kept.
- R9: A Start seen while the bus is already busy (a Restart) never makes the block drive SDA.
- R10: After a Stop, a kept request is launched again once the quiet period of R2 has passed.
- R11: `done` is high for exactly one cycle per outcome. `busy` is high whenever a request is pending or a transfer is in progress, and SDA is never pulled while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Sampled SCL line |
| sda_in | input | 1 | Sampled SDA line (wired-AND of all drivers) |
| dyn_addr | input | ADDR_W | Assigned dynamic address |
| ibi_req | input | 1 | One-cycle strobe that raises a request |
| avail_cycles | input | CNT_W | Quiet cycles required before launching |
| sda_pull_en | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | Request pending or transfer in progress |
| done | output | 1 | One-cycle pulse when an outcome is ready |
| outcome | output | 2 | 00 accepted, 01 refused, 10 lost to write, 11 passive NACK |

## Verification
The hardest situation to reach is the collision. Here the controller's header and the target's own request share a Start, so the two sides agree on every address bit and split only at the read/write or acknowledge bit. The bench plays the controller on a wired-AND SDA. It either issues its Start well before the quiet period ends, or it waits for the block's own Start and then drives a header of its own on top of it. Each vector chooses the header byte and the acknowledge level, so that arbitration is lost at a chosen bit, at the read/write bit, or not at all.

// File: rtl/ibi_pkg.sv
// Shared types for the in-band interrupt requester.
// Assumes: outcome codes are visible at the block's ports and must not change.
package ibi_pkg;

    // Outcome code presented with the done pulse.
    typedef enum logic [1:0] {
        OUT_ACCEPT  = 2'b00,
        OUT_REFUSED = 2'b01,
        OUT_LOST_WR = 2'b10,
        OUT_PASSIVE = 2'b11
    } ibi_outcome_e;

    // Sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_LAUNCH = 2'b01,
        ST_HDR    = 2'b10,
        ST_WAIT   = 2'b11
    } ibi_state_e;

endpackage

// File: rtl/ibi_bus_monitor.sv
// Watches the sampled SCL and SDA lines. It produces single-cycle edge
// events, bus-level Start and Stop events, and a bus-busy flag that is set
// by a Start and cleared by a Stop.
// Assumes: scl_in and sda_in are already synchronised to clk and idle high.
module ibi_bus_monitor (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_rise,
    output logic scl_fall,
    output logic any_edge,
    output logic start_evt,
    output logic stop_evt,
    output logic bus_busy
);

    logic scl_q;
    logic sda_q;
    logic busy_q;

    // Remember the previous line levels; the idle bus is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_in;
            sda_q <= sda_in;
        end
    end

    // Derive edge and bus-condition events from the previous and current levels.
    always_comb begin
        scl_rise  = scl_in & ~scl_q;
        scl_fall  = ~scl_in & scl_q;
        any_edge  = (scl_in ^ scl_q) | (sda_in ^ sda_q);
        start_evt = scl_q & scl_in & sda_q & ~sda_in;
        stop_evt  = scl_q & scl_in & ~sda_q & sda_in;
    end

    // Track whether a transfer is open between a Start and its Stop.
    always_ff @(posedge clk) begin
        if (!rst_n)         busy_q <= 1'b0;
        else if (start_evt) busy_q <= 1'b1;
        else if (stop_evt)  busy_q <= 1'b0;
    end

    assign bus_busy = busy_q;

    // R9
    bus_busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_q) && scl_q && $past(scl_in) && scl_in |-> !busy_q || $past(start_evt));

    // R9
    bus_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> bus_busy);

endmodule

// File: rtl/ibi_idle_timer.sv
// Counts consecutive cycles in which both lines are high with no edge
// and no open transfer. Flags the bus as available once the count reaches
// the programmed threshold. The count saturates at its maximum.
// Assumes: the threshold is held stable while a request waits.
module ibi_idle_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic             any_edge,
    input  logic             bus_busy,
    input  logic [CNT_W-1:0] threshold,
    output logic             bus_avail
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic             quiet;

    // A cycle counts as quiet only when nothing moves on a free, high bus.
    assign quiet = scl_in & sda_in & ~any_edge & ~bus_busy;

    // Count quiet cycles; any activity restarts the count.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (!quiet)         cnt_q <= '0;
        else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end

    assign bus_avail = ~bus_busy & (cnt_q >= threshold);

    // R2
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_edge |=> cnt_q == '0);

    // R2
    idle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        quiet && cnt_q != CNT_MAX |=> cnt_q == $past(cnt_q) + 1'b1);

endmodule

// File: rtl/ibi_header_arbiter.sv
// Sequencer for one in-band interrupt request. It latches the request,
// launches a Start when the bus is available, and shifts the address plus
// read bit onto SDA, checking each released bit for a loss. It then reads
// the acknowledge bit and reports one outcome with a one-cycle done pulse.
// Assumes: bits change while SCL is low and are valid at the SCL rising edge;
// dyn_addr is stable while a request is pending.
module ibi_header_arbiter
    import ibi_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_in,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              bus_busy,
    input  logic              bus_avail,
    input  logic [ADDR_W-1:0] dyn_addr,
    input  logic              req_pulse,
    output logic              sda_pull,
    output logic              busy,
    output logic              done,
    output logic [1:0]        outcome
);

    localparam int HDR_BITS = ADDR_W + 1;
    localparam int IDX_W    = $clog2(HDR_BITS + 1);
    localparam logic [IDX_W-1:0] RW_IDX  = IDX_W'(HDR_BITS - 1);
    localparam logic [IDX_W-1:0] ACK_IDX = IDX_W'(HDR_BITS);

    ibi_state_e          st_q;
    ibi_outcome_e        outcome_q;
    logic                sda_pull_q;
    logic                pending_q;
    logic                own_q;
    logic                done_q;
    logic [IDX_W-1:0]    idx_q;
    logic [HDR_BITS-1:0] hdr_q;
    logic                cur_bit;

    // The bit currently being presented is the MSB of the shift register.
    assign cur_bit = hdr_q[HDR_BITS-1];

    // Request latch, header sequencing, arbitration and outcome reporting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            outcome_q  <= OUT_ACCEPT;
            sda_pull_q <= 1'b0;
            pending_q  <= 1'b0;
            own_q      <= 1'b0;
            done_q     <= 1'b0;
            idx_q      <= '0;
            hdr_q      <= '0;
        end else begin
            done_q <= 1'b0;
            if (req_pulse) pending_q <= 1'b1;
            case (st_q)
                ST_IDLE: begin
                    sda_pull_q <= 1'b0;
                    if (pending_q && start_evt && !bus_busy) begin
                        st_q  <= ST_HDR;
                        own_q <= 1'b0;
                        idx_q <= '0;
                        hdr_q <= {dyn_addr, 1'b1};
                    end else if (pending_q && bus_avail) begin
                        st_q       <= ST_LAUNCH;
                        sda_pull_q <= 1'b1;
                        own_q      <= 1'b1;
                    end
                end
                ST_LAUNCH: begin
                    if (start_evt) begin
                        st_q  <= ST_HDR;
                        idx_q <= '0;
                        hdr_q <= {dyn_addr, 1'b1};
                    end
                end
                ST_HDR: begin
                    if (stop_evt) begin
                        st_q       <= ST_IDLE;
                        sda_pull_q <= 1'b0;
                    end else if (scl_fall) begin
                        sda_pull_q <= (idx_q < ACK_IDX) ? ~cur_bit : 1'b0;
                    end else if (scl_rise) begin
                        if (idx_q == ACK_IDX) begin
                            st_q   <= ST_WAIT;
                            done_q <= 1'b1;
                            if (!sda_in) begin
                                outcome_q <= OUT_ACCEPT;
                                pending_q <= 1'b0;
                            end else begin
                                outcome_q <= own_q ? OUT_REFUSED : OUT_PASSIVE;
                            end
                        end else if (cur_bit && !sda_in) begin
                            st_q       <= ST_WAIT;
                            sda_pull_q <= 1'b0;
                            if (idx_q == RW_IDX) begin
                                done_q    <= 1'b1;
                                outcome_q <= OUT_LOST_WR;
                            end
                        end else begin
                            idx_q <= idx_q + 1'b1;
                            hdr_q <= hdr_q << 1;
                        end
                    end
                end
                default: begin
                    sda_pull_q <= 1'b0;
                    if (stop_evt) st_q <= ST_IDLE;
                end
            endcase
        end
    end

    assign sda_pull = sda_pull_q;
    assign busy     = pending_q | (st_q != ST_IDLE);
    assign done     = done_q;
    assign outcome  = outcome_q;

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R11
    idle_no_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sda_pull_q);

    // R6
    accept_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q && outcome_q == OUT_ACCEPT |-> !pending_q);

    // R7
    keep_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q && outcome_q != OUT_ACCEPT |-> pending_q);

    // R9
    restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == ST_IDLE && start_evt && bus_busy |=> st_q == ST_IDLE && !sda_pull_q);

    // R4
    lost_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == ST_HDR && scl_rise && cur_bit && !sda_in && idx_q != ACK_IDX
        |=> !sda_pull_q && st_q == ST_WAIT);

    // R3
    pull_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_q) |-> $past(st_q) == ST_IDLE || $past(scl_fall));

endmodule

// File: rtl/ibi_requester.sv
// Top of the in-band interrupt requester. It joins the bus monitor, the
// idle timer and the header arbiter. SDA drive is open-drain: the output
// only asks for the line to be pulled low.
// Assumes: scl_in/sda_in are synchronised samples of the wired bus lines.
module ibi_requester #(
    parameter int ADDR_W = 7,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [ADDR_W-1:0] dyn_addr,
    input  logic              ibi_req,
    input  logic [CNT_W-1:0]  avail_cycles,
    output logic              sda_pull_en,
    output logic              busy,
    output logic              done,
    output logic [1:0]        outcome
);

    logic scl_rise;
    logic scl_fall;
    logic any_edge;
    logic start_evt;
    logic stop_evt;
    logic bus_busy;
    logic bus_avail;

    ibi_bus_monitor u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .any_edge  (any_edge),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .bus_busy  (bus_busy)
    );

    ibi_idle_timer #(.CNT_W(CNT_W)) u_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .any_edge  (any_edge),
        .bus_busy  (bus_busy),
        .threshold (avail_cycles),
        .bus_avail (bus_avail)
    );

    ibi_header_arbiter #(.ADDR_W(ADDR_W)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_in    (sda_in),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .bus_busy  (bus_busy),
        .bus_avail (bus_avail),
        .dyn_addr  (dyn_addr),
        .req_pulse (ibi_req),
        .sda_pull  (sda_pull_en),
        .busy      (busy),
        .done      (done),
        .outcome   (outcome)
    );

endmodule

// File: tb/ibi_requester_tb.sv
module ibi_requester_tb;

    localparam int THR = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        ctrl_sda = 1'b1;
    logic        req = 1'b0;
    logic [6:0]  addr = 7'h55;
    logic [15:0] thr = 16'(THR);
    logic        sda_pull_en, busy, done;
    logic [1:0]  outcome;
    logic        sda_wire;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int done_cnt = 0;
    int pull_cnt = 0;
    logic [1:0] last_out = 2'b00;
    logic watch_on = 1'b0;
    logic finished = 1'b0;

    always #5 clk = ~clk;

    assign sda_wire = ctrl_sda & ~sda_pull_en;

    ibi_requester u_dut (
        .clk (clk), .rst_n (rst_n), .scl_in (scl), .sda_in (sda_wire),
        .dyn_addr (addr), .ibi_req (req), .avail_cycles (thr),
        .sda_pull_en (sda_pull_en), .busy (busy), .done (done), .outcome (outcome)
    );

    // vector: own_start | ctrl header byte | ack_low | exp_done | exp_out | exp_busy | watch_from
    localparam logic [17:0] VEC [0:7] = '{
        {1'b1, 8'hFF, 1'b1, 1'b1, 2'd0, 1'b0, 4'd9},  // R6 accepted, R3 wire
        {1'b1, 8'hFF, 1'b0, 1'b1, 2'd1, 1'b1, 4'd9},  // R7 refused
        {1'b0, 8'hAA, 1'b0, 1'b1, 2'd2, 1'b1, 4'd9},  // R5 controller write
        {1'b0, 8'hAB, 1'b0, 1'b1, 2'd3, 1'b1, 4'd9},  // R8 passive NACK
        {1'b0, 8'h2B, 1'b0, 1'b0, 2'd0, 1'b1, 4'd1},  // R4 lost at first bit
        {1'b1, 8'hAA, 1'b0, 1'b1, 2'd2, 1'b1, 4'd9},  // R5 write on own Start
        {1'b0, 8'hAB, 1'b1, 1'b1, 2'd0, 1'b0, 4'd9},  // R6 acked on shared header
        {1'b0, 8'hA3, 1'b0, 1'b0, 2'd0, 1'b1, 4'd5}   // R4 lost at bit 4
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; scl = 1'b1; ctrl_sda = 1'b1; req = 1'b0; watch_on = 1'b0;
        tick(3);
        rst_n = 1'b1;
        done_cnt = 0; pull_cnt = 0;
    endtask

    task automatic pulse_req();
        req = 1'b1; tick(1); req = 1'b0;
    endtask

    task automatic run_bits(input logic [7:0] hdr, input logic ack_low,
                            input int watch_from, output logic [7:0] wire_bits);
        wire_bits = 8'h00;
        for (int i = 0; i < 9; i++) begin
            if (i == watch_from) watch_on = 1'b1;
            scl = 1'b0; tick(2);
            ctrl_sda = (i < 8) ? hdr[7-i] : ~ack_low;
            tick(2);
            scl = 1'b1; tick(1);
            if (i < 8) wire_bits[7-i] = sda_wire;
            tick(3);
        end
    endtask

    task automatic do_stop();
        scl = 1'b0; tick(2); ctrl_sda = 1'b0; tick(2);
        scl = 1'b1; tick(2); ctrl_sda = 1'b1; tick(3);
        watch_on = 1'b0;
    endtask

    // Collect done pulses and unexpected pulls away from the clock edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) begin
                done_cnt++;
                last_out = outcome;
            end
            if (watch_on && sda_pull_en) pull_cnt++;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc >= 100000 && !finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] wb;
        int waited;

        // R1 reset state
        rst_n = 1'b0;
        tick(3);
        check(sda_pull_en == 1'b0, "R1 sda_pull_en", sda_pull_en, 0);
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(done == 1'b0, "R1 done", done, 0);
        check(outcome == 2'b00, "R1 outcome", outcome, 0);
        rst_n = 1'b1;
        tick(1);
        check(busy == 1'b0 && sda_pull_en == 1'b0, "R1 after release", busy, 0);

        // Vector table
        for (int v = 0; v < 8; v++) begin
            logic [17:0] e;
            e = VEC[v];
            do_reset();
            pulse_req();
            if (e[17]) begin
                waited = 0;
                while (!sda_pull_en && waited < 200) begin tick(1); waited++; end
                check(sda_pull_en == 1'b1, "R2 launch", sda_pull_en, 1);
                tick(3);
            end else begin
                tick(3);
                ctrl_sda = 1'b0;
                tick(3);
            end
            run_bits(e[16:9], e[8], int'(e[3:0]), wb);
            do_stop();
            check(done_cnt == int'(e[7]), $sformatf("R11 done count v%0d", v), done_cnt, e[7]);
            if (e[7])
                check(last_out == e[6:5], $sformatf("R5 R6 R7 R8 outcome v%0d", v), last_out, e[6:5]);
            check(busy == e[4], $sformatf("R6 R11 busy v%0d", v), busy, e[4]);
            if (e[3:0] != 4'd9)
                check(pull_cnt == 0, $sformatf("R4 pull after loss v%0d", v), pull_cnt, 0);
            if (e[17] && e[16:9] == 8'hFF)
                check(wb == 8'hAB, $sformatf("R3 wire header v%0d", v), wb, 8'hAB);
        end

        // R2: bus-available timing and restart of the count by an edge
        do_reset();
        pulse_req();
        tick(THR - 5);
        scl = 1'b0; tick(1); scl = 1'b1;
        tick(THR - 3);
        check(sda_pull_en == 1'b0, "R2 no early launch", sda_pull_en, 0);
        tick(8);
        check(sda_pull_en == 1'b1, "R2 launch after quiet", sda_pull_en, 1);

        // R9: restart while bus busy, then R10 retry after Stop
        do_reset();
        tick(2);
        ctrl_sda = 1'b0; tick(3);
        run_bits(8'h00, 1'b0, 9, wb);
        pulse_req();
        scl = 1'b0; tick(2); ctrl_sda = 1'b1; tick(2);
        scl = 1'b1; tick(2); ctrl_sda = 1'b0; tick(3);
        watch_on = 1'b1;
        run_bits(8'hAA, 1'b0, 0, wb);
        do_stop();
        check(pull_cnt == 0, "R9 no drive after restart", pull_cnt, 0);
        check(done_cnt == 0, "R9 no outcome", done_cnt, 0);
        check(busy == 1'b1, "R11 pending kept busy", busy, 1);
        tick(THR + 6);
        check(sda_pull_en == 1'b1, "R10 retry launch", sda_pull_en, 1);

        // R10: retry after a refusal
        do_reset();
        pulse_req();
        waited = 0;
        while (!sda_pull_en && waited < 200) begin tick(1); waited++; end
        tick(3);
        run_bits(8'hFF, 1'b0, 9, wb);
        do_stop();
        check(last_out == 2'b01, "R7 refused before retry", last_out, 1);
        tick(THR + 6);
        check(sda_pull_en == 1'b1, "R10 retry after refusal", sda_pull_en, 1);

        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule